// File: doc/BRIEF.md
# Logic-in-Memory Matrix Cell Array

This block is a two-dimensional grid of storage cells in which every cell owns a small arithmetic and logic unit. Each cell keeps four words, named A, B, C and T. One broadcast command is issued to the whole grid, and all cells run it on the same clock edge. Because of this, one command performs an elementwise operation over whole matrices held across the grid.

A dyadic command has a direction bit that picks one of two fixed pairings. With direction 0, A and B are combined and the result goes to C. With direction 1, C and B are combined and the result goes to A. B is always the right-hand operand. Every successful dyadic result is also copied into T, which acts as the scratch copy of the last result. A complement command inverts one chosen register in place. A host port loads or reads one full row of one register per cycle. The port uses a row index and a register-select code.

A small sequencer runs each command. Its states are IDLE, EXEC and DONE. The transitions are:
- IDLE to EXEC when `start` is high.
- EXEC to DONE unconditionally.
- DONE to IDLE unconditionally.

The cells update at the end of EXEC. `done` is high during DONE.

Top module: `lim_array`

## Requirements
- R1: After reset, every word of A, B, C and T in every cell reads 0, and `busy`, `done` and `any_fault` are 0.
- R2: Register-select codes are A=0, B=1, C=2 and T=3. When `wr_en` is high in IDLE, the edge writes `wr_data` (column k at bits k*W upward) into the row `row_idx` of the selected register. `rd_data` shows the selected row and register combinationally, and shows 0 for a row index at or beyond ROWS.
- R3: With `dir`=0, a dyadic command writes f(A,B) to C. With `dir`=1, it writes f(C,B) to A. B is never changed by a dyadic command, and every cell updates on the same edge.
- R4: Op codes 0, 1 and 2 are add, subtract and multiply. Each keeps the low W bits of the result, so it wraps modulo 2^W.
- R5: Op codes 4 and 5 are bitwise OR and bitwise AND.
- R6: Op codes 6, 7 and 8 are the unsigned comparisons less-than, equal and greater-than. Each writes 1 when true and 0 when false.
- R7: Op code 3 is unsigned truncating divide. In a cell whose B is 0:
  - the destination and T stay unchanged;
  - that cell's fault bit is set.
  
  `any_fault` is the OR of all fault bits. Every cell's fault bit is rewritten by each later command, and only a divide by zero sets it.
- R8: Op code 9 inverts every bit of the register chosen by `reg_sel` in every cell. All other registers are left unchanged. Op codes 10 to 15 leave every register unchanged.
- R9: T receives the same value as the destination on every dyadic command that writes a result.
- R10: The command is sampled on the `start` edge in IDLE, and the cells update on the following edge. `done` is high for the one cycle after that update, and `busy` is high during EXEC and DONE. `start` and `wr_en` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command strobe |
| op | input | 4 | Operation code |
| dir | input | 1 | 0: (A,B) into C, 1: (C,B) into A |
| reg_sel | input | 2 | Register select for the host port and the complement target |
| row_idx | input | RW | Row index for the host port |
| wr_en | input | 1 | Row write enable |
| wr_data | input | COLS*W | Row write data |
| rd_data | output | COLS*W | Row read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed |
| any_fault | output | 1 | OR of the per-cell divide faults |

## Verification
The bench builds the array with 4 rows, 3 columns and 16-bit words. At this size, a full readback of all four registers after each command takes only 16 reads, so every op code can be run in both directions over fresh patterns. Three columns do not fill a power-of-two row width, which tests how the column slicing lines up. The patterns include 0xFFFF, 0x8000, equal operands and a zero divisor placed in one cell of every three. These values reach the wrap, compare-true and divide-fault cases in cells that sit next to cells which are not faulting.

// File: rtl/lim_pkg.sv
package lim_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_OR  = 4'd4,
        OP_AND = 4'd5,
        OP_LT  = 4'd6,
        OP_EQ  = 4'd7,
        OP_GT  = 4'd8,
        OP_NOT = 4'd9
    } lim_op_e;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2,
        SEL_T = 2'd3
    } lim_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } lim_state_e;

    typedef struct packed {
        lim_op_e  op;
        logic     dir;
        lim_sel_e sel;
    } lim_cmd_t;

endpackage

// File: rtl/lim_ctrl.sv
module lim_ctrl
    import lim_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       wr_en,
    input  logic [3:0] op_in,
    input  logic       dir_in,
    input  logic [1:0] sel_in,
    output logic       exec,
    output logic       busy,
    output logic       done,
    output logic       wr_accept,
    output lim_cmd_t   cmd
);

    lim_state_e state_q, state_d;
    lim_cmd_t   cmd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '{op: OP_ADD, dir: 1'b0, sel: SEL_A};
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                cmd_q.op  <= lim_op_e'(op_in);
                cmd_q.dir <= dir_in;
                cmd_q.sel <= lim_sel_e'(sel_in);
            end
        end
    end

    always_comb begin
        exec      = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        wr_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy      = 1'b0;
                wr_accept = wr_en;
            end
            ST_EXEC: exec = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign cmd = cmd_q;

    // R10
    done_follows_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> done);

    // R10
    exec_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> exec);

    // R10
    phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exec, done}));

    // R10
    no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_accept);

endmodule

// File: rtl/lim_cell_alu.sv
module lim_cell_alu
    import lim_pkg::*;
#(
    parameter int W = 16
) (
    input  lim_op_e        op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   res,
    output logic           wr,
    output logic           div_fault
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        res       = '0;
        wr        = 1'b1;
        div_fault = 1'b0;
        case (op)
            OP_ADD: res = x + y;
            OP_SUB: res = x - y;
            OP_MUL: res = x * y;
            OP_DIV: begin
                if (y == '0) begin
                    wr        = 1'b0;
                    div_fault = 1'b1;
                end else begin
                    res = x / y;
                end
            end
            OP_OR:  res = x | y;
            OP_AND: res = x & y;
            OP_LT:  res = (x < y)  ? ONE : '0;
            OP_EQ:  res = (x == y) ? ONE : '0;
            OP_GT:  res = (x > y)  ? ONE : '0;
            default: wr = 1'b0;
        endcase
    end

endmodule

// File: rtl/lim_cell.sv
module lim_cell
    import lim_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec,
    input  lim_cmd_t     cmd,
    input  logic         wr_row,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_word,
    output logic [W-1:0] a_o,
    output logic [W-1:0] b_o,
    output logic [W-1:0] c_o,
    output logic [W-1:0] t_o,
    output logic         fault_o
);

    logic [W-1:0] a_q, b_q, c_q, t_q;
    logic         fault_q;
    logic [W-1:0] lhs, res;
    logic         res_wr, div_fault;

    assign lhs = cmd.dir ? c_q : a_q;

    lim_cell_alu #(.W(W)) u_alu (
        .op        (cmd.op),
        .x         (lhs),
        .y         (b_q),
        .res       (res),
        .wr        (res_wr),
        .div_fault (div_fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            c_q     <= '0;
            t_q     <= '0;
            fault_q <= 1'b0;
        end else if (exec) begin
            fault_q <= div_fault;
            if (cmd.op == OP_NOT) begin
                unique case (cmd.sel)
                    SEL_A: a_q <= ~a_q;
                    SEL_B: b_q <= ~b_q;
                    SEL_C: c_q <= ~c_q;
                    SEL_T: t_q <= ~t_q;
                endcase
            end else if (res_wr) begin
                t_q <= res;
                if (cmd.dir) a_q <= res;
                else         c_q <= res;
            end
        end else if (wr_row) begin
            unique case (lim_sel_e'(wr_sel))
                SEL_A: a_q <= wr_word;
                SEL_B: b_q <= wr_word;
                SEL_C: c_q <= wr_word;
                SEL_T: t_q <= wr_word;
            endcase
        end
    end

    assign a_o     = a_q;
    assign b_o     = b_q;
    assign c_o     = c_q;
    assign t_o     = t_q;
    assign fault_o = fault_q;

    // R3
    b_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cmd.op != OP_NOT) |=> b_q == $past(b_q));

    // R7
    div_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && cmd.op == OP_DIV && b_q == '0) |=>
            (a_q == $past(a_q) && c_q == $past(c_q) && t_q == $past(t_q) && fault_q));

    // R6
    cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (cmd.op == OP_LT || cmd.op == OP_EQ || cmd.op == OP_GT)) |=>
            (t_q[W-1:1] == '0));

    // R10
    cell_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec && !wr_row) |=>
            (a_q == $past(a_q) && b_q == $past(b_q) && c_q == $past(c_q) &&
             t_q == $past(t_q) && fault_q == $past(fault_q)));

    // R7
    fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(exec));

endmodule

// File: rtl/lim_array.sv
module lim_array
    import lim_pkg::*;
#(
    parameter int ROWS = 32,
    parameter int COLS = 32,
    parameter int W    = 16,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic              dir,
    input  logic [1:0]        reg_sel,
    input  logic [RW-1:0]     row_idx,
    input  logic              wr_en,
    input  logic [COLS*W-1:0] wr_data,
    output logic [COLS*W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              any_fault
);

    localparam int NCELL = ROWS * COLS;

    logic     exec, wr_accept;
    lim_cmd_t cmd;

    logic [W-1:0]     a_w [ROWS][COLS];
    logic [W-1:0]     b_w [ROWS][COLS];
    logic [W-1:0]     c_w [ROWS][COLS];
    logic [W-1:0]     t_w [ROWS][COLS];
    logic [NCELL-1:0] fault_w;

    lim_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr_en     (wr_en),
        .op_in     (op),
        .dir_in    (dir),
        .sel_in    (reg_sel),
        .exec      (exec),
        .busy      (busy),
        .done      (done),
        .wr_accept (wr_accept),
        .cmd       (cmd)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic row_hit;
        assign row_hit = wr_accept && (row_idx == RW'(r));
        for (genvar c = 0; c < COLS; c++) begin : g_col
            lim_cell #(.W(W)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .exec    (exec),
                .cmd     (cmd),
                .wr_row  (row_hit),
                .wr_sel  (reg_sel),
                .wr_word (wr_data[c*W +: W]),
                .a_o     (a_w[r][c]),
                .b_o     (b_w[r][c]),
                .c_o     (c_w[r][c]),
                .t_o     (t_w[r][c]),
                .fault_o (fault_w[r*COLS + c])
            );
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_idx == RW'(r)) begin
                for (int c = 0; c < COLS; c++) begin
                    unique case (lim_sel_e'(reg_sel))
                        SEL_A: rd_data[c*W +: W] = a_w[r][c];
                        SEL_B: rd_data[c*W +: W] = b_w[r][c];
                        SEL_C: rd_data[c*W +: W] = c_w[r][c];
                        SEL_T: rd_data[c*W +: W] = t_w[r][c];
                    endcase
                end
            end
        end
    end

    assign any_fault = |fault_w;

    // R7
    fault_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec) |=> any_fault == $past(any_fault));

endmodule

// File: tb/lim_array_tb.sv
module lim_array_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 4;
    localparam int COLS = 3;
    localparam int W    = 16;
    localparam int RW   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        op = '0;
    logic              dir = 1'b0;
    logic [1:0]        reg_sel = '0;
    logic [RW-1:0]     row_idx = '0;
    logic              wr_en = 1'b0;
    logic [COLS*W-1:0] wr_data = '0;
    logic [COLS*W-1:0] rd_data;
    logic              busy, done, any_fault;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    lim_array #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dir(dir),
        .reg_sel(reg_sel), .row_idx(row_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy), .done(done), .any_fault(any_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [W-1:0] m [4][ROWS][COLS];
    bit           mf [ROWS][COLS];
    int           ph = 0;
    int           l_op;
    bit           l_dir;
    int           l_sel;

    task automatic model_exec();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                logic [W-1:0] x, y, res;
                bit ok;
                x  = l_dir ? m[2][r][c] : m[0][r][c];
                y  = m[1][r][c];
                ok = 1;
                mf[r][c] = 0;
                res = '0;
                case (l_op)
                    0: res = x + y;
                    1: res = x - y;
                    2: res = W'(int'(x) * int'(y));
                    3: if (y == 0) begin ok = 0; mf[r][c] = 1; end
                       else res = W'(int'(x) / int'(y));
                    4: res = x | y;
                    5: res = x & y;
                    6: res = (int'(x) <  int'(y)) ? 1 : 0;
                    7: res = (int'(x) == int'(y)) ? 1 : 0;
                    8: res = (int'(x) >  int'(y)) ? 1 : 0;
                    default: ok = 0;
                endcase
                if (l_op == 9) m[l_sel][r][c] = ~m[l_sel][r][c];
                else if (ok) begin
                    m[3][r][c] = res;
                    if (l_dir) m[0][r][c] = res;
                    else       m[2][r][c] = res;
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            for (int s = 0; s < 4; s++)
                for (int r = 0; r < ROWS; r++)
                    for (int c = 0; c < COLS; c++) m[s][r][c] = '0;
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) mf[r][c] = 0;
        end else begin
            case (ph)
                0: begin
                    if (wr_en && int'(row_idx) < ROWS)
                        for (int c = 0; c < COLS; c++)
                            m[reg_sel][row_idx][c] = wr_data[c*W +: W];
                    if (start) begin
                        l_op = int'(op); l_dir = dir; l_sel = int'(reg_sel);
                        ph = 1;
                    end
                end
                1: begin model_exec(); ph = 2; end
                default: ph = 0;
            endcase
        end
    end

    function automatic bit model_fault();
        bit f = 0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) f |= mf[r][c];
        return f;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of flags and the current read port view
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && !finished) begin
                chk("R10 busy", busy, (ph != 0));
                chk("R10 done", done, (ph == 2));
                chk("R7 any_fault", any_fault, model_fault());
                for (int c = 0; c < COLS; c++)
                    chk("R2 read port", rd_data[c*W +: W], m[reg_sel][row_idx][c]);
            end
        end
    end

    function automatic logic [W-1:0] pat(input int seed, input int s, input int r,
                                         input int c, input bit bzero);
        logic [31:0] h;
        logic [W-1:0] v;
        h = (32'(seed) * 32'd40503 + 32'(s) * 32'd9973 + 32'(r) * 32'd613 +
             32'(c) * 32'd211 + 32'd1) * 32'd2654435761;
        v = h[31:16];
        if (r == 0 && c == 0) begin
            if (s == 0) v = 16'hFFFF;
            if (s == 1) v = 16'h0002;
            if (s == 2) v = 16'h8000;
        end
        if (r == 0 && c == 1 && s < 3) v = 16'h1234;
        if (r == 1 && c == 2 && s == 1) v = 16'hFFFF;
        if (s == 1 && bzero && ((r + c) % 3 == 0)) v = '0;
        if (s == 1 && !bzero && v == 0) v = 16'h0001;
        return v;
    endfunction

    task automatic fill(input int seed, input bit bzero);
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < ROWS; r++) begin
                @(negedge clk);
                wr_en = 1'b1; reg_sel = 2'(s); row_idx = RW'(r);
                for (int c = 0; c < COLS; c++) wr_data[c*W +: W] = pat(seed, s, r, c, bzero);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic readback(input string tag);
        for (int s = 0; s < 4; s++) begin
            for (int r = 0; r < ROWS; r++) begin
                @(negedge clk);
                reg_sel = 2'(s); row_idx = RW'(r);
                #1;
                for (int c = 0; c < COLS; c++)
                    chk(tag, rd_data[c*W +: W], m[s][r][c]);
            end
        end
    endtask

    task automatic run_op(input int o, input bit d, input int s);
        @(negedge clk);
        start = 1'b1; op = 4'(o); dir = d; reg_sel = 2'(s);
        @(negedge clk);
        start = 1'b0;
        #1 chk("R10 busy in EXEC", {busy, done}, 2'b10);
        @(negedge clk);
        #1 chk("R10 done after update", {busy, done}, 2'b11);
        @(negedge clk);
        #1 chk("R10 back to idle", {busy, done}, 2'b00);
    endtask

    function automatic string op_tag(input int o);
        case (o)
            0, 1, 2: return "R4 R3 R9";
            3:       return "R7 R3 R9";
            4, 5:    return "R5 R3 R9";
            6, 7, 8: return "R6 R3 R9";
            9:       return "R8";
            default: return "R8 reserved";
        endcase
    endfunction

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1;
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 flags in reset", {busy, done, any_fault}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1 flags after reset", {busy, done, any_fault}, 3'b000);
        readback("R1 reset contents");

        // write and read every register
        fill(100, 1'b0);
        readback("R2 write readback");

        // out-of-range row is not reachable with ROWS=4 and RW=2; all rows covered
        // every dyadic op, both directions
        for (int o = 0; o < 9; o++) begin
            for (int d = 0; d < 2; d++) begin
                fill(o * 2 + d, (o == 3));
                run_op(o, d[0], 0);
                readback(op_tag(o));
            end
        end

        // R7: fault then cleared by the next command, and divide with no zero divisor
        fill(50, 1'b1);
        run_op(3, 1'b0, 0);
        #1 chk("R7 fault raised", any_fault, 1'b1);
        run_op(0, 1'b0, 0);
        #1 chk("R7 fault cleared", any_fault, 1'b0);
        fill(51, 1'b0);
        run_op(3, 1'b1, 0);
        #1 chk("R7 no fault nonzero divisor", any_fault, 1'b0);
        readback("R7 divide");

        // R8: complement each register in turn
        for (int s = 0; s < 4; s++) begin
            fill(60 + s, 1'b0);
            run_op(9, 1'b0, s);
            readback("R8 complement");
        end

        // R8: reserved codes change nothing
        fill(70, 1'b0);
        run_op(12, 1'b1, 0);
        readback("R8 reserved code");

        // R10: start and write during busy are ignored
        fill(80, 1'b0);
        @(negedge clk);
        start = 1'b1; op = 4'd0; dir = 1'b0; reg_sel = 2'd0;
        @(negedge clk);
        start = 1'b1; op = 4'd1; dir = 1'b1;
        wr_en = 1'b1; row_idx = '0; reg_sel = 2'd1; wr_data = '1;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        #1 chk("R10 done with busy inputs", done, 1'b1);
        @(negedge clk);
        #1 chk("R10 idle after ignored start", busy, 1'b0);
        readback("R10 busy inputs ignored");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule